// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block drives a two-wire serial bus as a master that only ever writes. Software sets a 7-bit target address, an SCL prescale and separate low/high divider values, raises the enable, and then writes a byte into the holding register. That first write opens a transfer. The block sends a start condition and the address with a write direction bit. After that it sends data bytes one by one, as long as software refills the holding register before each byte is acknowledged. When the holding register is empty at an acknowledge, or when the target refuses a byte, the block closes the transfer with a stop condition on its own.

Three status flags carry the handshake. `txrdy` reports that the holding register is empty again. `txcomp` reports that the bus has gone back to idle. `nack` reports that a byte was refused. Each flag can be routed to the single interrupt output through a mask. Both bus lines are open-drain: an `*_oe` output of 1 pulls the line low, and 0 releases it.

The controller has seven states. IDLE goes to START on an accepted write. START goes to LOW and LOW goes to HIGH when the phase timer expires. HIGH goes back to LOW after a data bit, or after an acknowledged ninth pulse when a byte is pending. HIGH goes to STOP_LOW after the ninth pulse when the byte was refused or nothing is pending. STOP_LOW goes to STOP_HIGH, STOP_HIGH goes to BUS_FREE, and BUS_FREE goes back to IDLE.

Top module: `twm_write_master`

## Requirements
- R1: During and right after reset, `scl_oe`, `sda_oe`, `txrdy`, `txcomp`, `nack` and `irq` are all 0.
- R2: A `tx_wr` pulse while `enable` is 1 and the block is idle opens exactly one start condition: SDA falls while SCL is released. `txcomp` reads 0 from the following cycle.
- R3: The first byte on the bus is `dev_addr` followed by a 0 direction bit. Every byte goes out MSB first. Outside start and stop, SDA changes only while SCL is low.
- R4: On the ninth pulse of each byte the master releases SDA and samples it in the last cycle of the SCL high phase. A low sample is an acknowledge: `txrdy` becomes 1, and the pending holding-register byte, if any, moves into the shifter.
- R5: A byte written before the acknowledge of the current byte, including a write in the acknowledge cycle itself, is sent next with no stop in between. A write clears `txrdy`.
- R6: If nothing is pending at an acknowledge, the master drives SCL low once more, releases SCL, releases SDA while SCL is high (stop), waits one high period, and sets `txcomp` on entering idle.
- R7: A high sample on the ninth pulse sets `nack`, leads to the same stop and `txcomp` sequence, and drops any pending byte, which is never sent.
- R8: `irq` is 1 exactly when an enabled flag is set. The mask bits are: bit 0 for `txrdy`, bit 1 for `txcomp`, bit 2 for `nack`.
- R9: A `stat_rd` pulse clears `nack`. A new refusal in the same cycle keeps it set.
- R10: Every SCL low phase lasts (`div_lo` << `clk_pre`) + 4 clock cycles. Every SCL high phase of a bit lasts (`div_hi` << `clk_pre`) + 4 clock cycles.
- R11: A `tx_wr` while `enable` is 0 and the block is idle causes no bus activity and leaves every flag unchanged.

Writes that arrive once the stop sequence has begun are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable |
| dev_addr | input | 7 | Target device address |
| clk_pre | input | PRE_W | Shift applied to both dividers |
| div_lo | input | DIV_W | SCL low divider |
| div_hi | input | DIV_W | SCL high divider |
| tx_wr | input | 1 | Holding-register write strobe |
| tx_data | input | 8 | Holding-register write data |
| stat_rd | input | 1 | Status read strobe, clears `nack` |
| irq_mask | input | 3 | Interrupt enables {nack, txcomp, txrdy} |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| txrdy | output | 1 | Holding register empty |
| txcomp | output | 1 | Transfer complete, bus idle |
| nack | output | 1 | Byte refused by the target |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with `DIV_W = 3` and `PRE_W = 1`. This makes the whole timing space small: 2 prescale values × 8 low dividers × 8 high dividers, 128 settings in all. Every setting is run once with a one-byte transfer. The measured SCL phase widths are compared with the arithmetic formula, and each setting uses its own address and data pattern. With those small widths, separate directed transfers cover a refused address, a refused data byte with a byte already pending, a four-byte streamed transfer, a write while disabled, and the interrupt masking.

// File: rtl/twm_pkg.sv
`timescale 1ns/1ps
package twm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_BUS_FREE
    } bus_state_e;

    localparam int FLAG_TXRDY  = 0;
    localparam int FLAG_TXCOMP = 1;
    localparam int FLAG_NACK   = 2;
    localparam int FLAG_NUM    = 3;

endpackage

// File: rtl/twm_phase_timer.sv
`timescale 1ns/1ps
module twm_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/twm_shifter.sv
`timescale 1ns/1ps
module twm_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              advance,
    output logic              bit_out,
    output logic              ack_slot
);

    localparam int IDX_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sr;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            idx <= '0;
        end else if (load) begin
            sr  <= din;
            idx <= '0;
        end else if (advance) begin
            sr  <= {sr[BYTE_W-2:0], 1'b0};
            idx <= idx + IDX_W'(1);
        end
    end

    assign bit_out  = sr[BYTE_W-1];
    assign ack_slot = (idx == IDX_W'(BYTE_W));

endmodule

// File: rtl/twm_write_master.sv
`timescale 1ns/1ps
module twm_write_master
    import twm_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [6:0]       dev_addr,
    input  logic [PRE_W-1:0] clk_pre,
    input  logic [DIV_W-1:0] div_lo,
    input  logic [DIV_W-1:0] div_hi,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    input  logic             stat_rd,
    input  logic [2:0]       irq_mask,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             txrdy,
    output logic             txcomp,
    output logic             nack,
    output logic             irq
);

    localparam int CNT_W  = DIV_W + (1 << PRE_W);
    localparam int BYTE_W = 8;

    bus_state_e state, state_n;

    logic             expire, tmr_load;
    logic [CNT_W-1:0] lo_len, hi_len, tmr_len;
    logic             sh_load, sh_adv, sh_bit, ack_slot;
    logic [BYTE_W-1:0] sh_din;
    logic [BYTE_W-1:0] hold;
    logic             hold_full;
    logic             start_go, busy_wr, byte_end, got_ack, pend;
    logic [BYTE_W-1:0] pend_data;
    logic             sda_want;

    assign lo_len = (CNT_W'(div_lo) << clk_pre) + CNT_W'(4);
    assign hi_len = (CNT_W'(div_hi) << clk_pre) + CNT_W'(4);

    assign start_go  = (state == ST_IDLE) && enable && tx_wr;
    assign busy_wr   = tx_wr && (state inside {ST_START, ST_LOW, ST_HIGH});
    assign byte_end  = (state == ST_HIGH) && expire && ack_slot;
    assign got_ack   = byte_end && !sda_in;
    assign pend      = hold_full || busy_wr;
    assign pend_data = busy_wr ? tx_data : hold;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      if (start_go) state_n = ST_START;
            ST_START:     if (expire) state_n = ST_LOW;
            ST_LOW:       if (expire) state_n = ST_HIGH;
            ST_HIGH: begin
                if (expire) begin
                    if (!ack_slot)          state_n = ST_LOW;
                    else if (got_ack && pend) state_n = ST_LOW;
                    else                    state_n = ST_STOP_LOW;
                end
            end
            ST_STOP_LOW:  if (expire) state_n = ST_STOP_HIGH;
            ST_STOP_HIGH: if (expire) state_n = ST_BUS_FREE;
            ST_BUS_FREE:  if (expire) state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    assign tmr_load = (state_n != state);
    assign tmr_len  = (state_n == ST_LOW || state_n == ST_STOP_LOW) ? lo_len : hi_len;

    twm_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .expire (expire)
    );

    assign sh_load = start_go || (got_ack && pend);
    assign sh_din  = start_go ? {dev_addr, 1'b0} : pend_data;
    assign sh_adv  = (state == ST_HIGH) && expire && !ack_slot;

    twm_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .din      (sh_din),
        .advance  (sh_adv),
        .bit_out  (sh_bit),
        .ack_slot (ack_slot)
    );

    // output decode: SCL from state, SDA one cycle behind
    always_comb begin
        scl_oe = (state == ST_LOW) || (state == ST_STOP_LOW);
        unique case (state)
            ST_START, ST_STOP_LOW, ST_STOP_HIGH: sda_want = 1'b1;
            ST_LOW, ST_HIGH:                     sda_want = !ack_slot && !sh_bit;
            default:                             sda_want = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_oe <= 1'b0;
        else        sda_oe <= sda_want;
    end

    // holding register and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
            txrdy     <= 1'b0;
            txcomp    <= 1'b0;
            nack      <= 1'b0;
        end else begin
            if (start_go) begin
                hold      <= tx_data;
                hold_full <= 1'b1;
                txrdy     <= 1'b0;
                txcomp    <= 1'b0;
            end else if (busy_wr) begin
                hold      <= tx_data;
                hold_full <= 1'b1;
                txrdy     <= 1'b0;
            end
            if (stat_rd) nack <= 1'b0;
            if (byte_end) begin
                if (sda_in) begin
                    nack      <= 1'b1;
                    hold_full <= 1'b0;
                end else begin
                    txrdy <= 1'b1;
                    if (pend) hold_full <= 1'b0;
                end
            end
            if (state == ST_BUS_FREE && expire) begin
                txcomp    <= 1'b1;
                hold_full <= 1'b0;
            end
        end
    end

    logic [FLAG_NUM-1:0] flags;
    always_comb begin
        flags              = '0;
        flags[FLAG_TXRDY]  = txrdy;
        flags[FLAG_TXCOMP] = txcomp;
        flags[FLAG_NACK]   = nack;
    end
    assign irq = |(flags & irq_mask);

endmodule

// File: rtl/twm_write_master_chk.sv
`timescale 1ns/1ps
module twm_write_master_chk
    import twm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input bus_state_e state,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       txrdy,
    input logic       txcomp,
    input logic       nack,
    input logic       tx_wr
);

    // R2: an idle bus stays released on both lines
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!scl_oe && !sda_oe));

    // R3: SDA may only be pulled while SCL is high as part of a start
    a_r3_pull_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (state == ST_START));

    // R6: SDA may only be released while SCL is high as part of a stop
    a_r6_release_only_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> (state == ST_BUS_FREE));

    // R6: completion is flagged only with the bus back at idle
    a_r6_txcomp_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txcomp) |-> (state == ST_IDLE && !scl_oe && !sda_oe));

    // R7: a refusal is followed straight away by the stop sequence
    a_r7_nack_goes_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack) |-> (state == ST_STOP_LOW));

    // R5: a write during a data low phase leaves the holding register busy
    a_r5_write_clears_txrdy: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && state == ST_LOW) |=> !txrdy);

endmodule

bind twm_write_master twm_write_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .txrdy  (txrdy),
    .txcomp (txcomp),
    .nack   (nack),
    .tx_wr  (tx_wr)
);

// File: tb/tb_twm_write_master.sv
`timescale 1ns/1ps
module tb_twm_write_master;

    localparam int DIV_W = 3;
    localparam int PRE_W = 1;
    localparam int CLK_NS = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             enable;
    logic [6:0]       dev_addr;
    logic [PRE_W-1:0] clk_pre;
    logic [DIV_W-1:0] div_lo, div_hi;
    logic             tx_wr;
    logic [7:0]       tx_data;
    logic             stat_rd;
    logic [2:0]       irq_mask;
    logic             scl_oe, sda_oe, txrdy, txcomp, nack, irq;
    logic             scl_line, sda_line;
    logic             sl_pull = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | sl_pull);

    twm_write_master #(.DIV_W(DIV_W), .PRE_W(PRE_W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dev_addr(dev_addr),
        .clk_pre(clk_pre), .div_lo(div_lo), .div_hi(div_hi),
        .tx_wr(tx_wr), .tx_data(tx_data), .stat_rd(stat_rd),
        .irq_mask(irq_mask), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .txrdy(txrdy),
        .txcomp(txcomp), .nack(nack), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural target model ----------------
    logic [6:0] sl_addr = 7'h00;
    int         sl_ack_limit = 0;
    int         bit_cnt = 0, byte_idx = 0, rx_n = 0, starts = 0, stops = 0;
    bit         in_ack = 0, seen_fall = 0;
    logic [7:0] shreg = 8'h00;
    logic [7:0] rx [0:15];
    time        t_fall = 0, t_rise = 0;
    int         lo_min, lo_max, hi_min, hi_max;
    logic       p_scl = 1'b1, p_sda = 1'b1;

    task automatic slave_clear();
        rx_n = 0; starts = 0; stops = 0;
        lo_min = 1000; lo_max = 0; hi_min = 1000; hi_max = 0;
    endtask

    always @(scl_line, sda_line) begin
        if (!rst_n) begin
            sl_pull = 1'b0;
            in_ack  = 0;
        end else if (sda_line !== p_sda && scl_line === 1'b1 && p_scl === 1'b1) begin
            if (sda_line === 1'b0) begin
                starts++; bit_cnt = 0; byte_idx = 0; in_ack = 0; seen_fall = 0;
            end else begin
                stops++;
            end
        end else if (scl_line === 1'b1 && p_scl === 1'b0) begin
            if (seen_fall) begin
                int w;
                w = int'(($time - t_fall) / CLK_NS);
                if (w < lo_min) lo_min = w;
                if (w > lo_max) lo_max = w;
            end
            t_rise = $time;
            if (!in_ack && bit_cnt < 8) begin
                shreg = {shreg[6:0], sda_line};
                bit_cnt++;
            end
        end else if (scl_line === 1'b0 && p_scl === 1'b1) begin
            if (seen_fall) begin
                int w;
                w = int'(($time - t_rise) / CLK_NS);
                if (w < hi_min) hi_min = w;
                if (w > hi_max) hi_max = w;
            end
            seen_fall = 1;
            t_fall = $time;
            if (in_ack) begin
                in_ack = 0; sl_pull = 1'b0; bit_cnt = 0;
            end else if (bit_cnt == 8) begin
                bit ack;
                if (rx_n < 16) rx[rx_n] = shreg;
                rx_n++;
                ack = (byte_idx == 0) ? (shreg == {sl_addr, 1'b0}) : (byte_idx <= sl_ack_limit);
                byte_idx++;
                in_ack = 1;
                sl_pull = ack;
            end
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_byte(input logic [7:0] d);
        tx_wr = 1'b1; tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // returns the number of bytes actually written to the holding register
    task automatic run_xfer(input int nbytes, input logic [7:0] base,
                            input logic [7:0] step, output int written);
        slave_clear();
        write_byte(base);
        written = 1;
        for (int k = 1; k < nbytes; k++) begin
            while (!txrdy && !txcomp) @(negedge clk);
            if (txcomp) break;
            write_byte(8'(base + k * step));
            written++;
        end
        while (!txcomp) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sweep_one(input int p, input int l, input int h);
        int idx, wr, lo_exp, hi_exp;
        logic [6:0] a;
        logic [7:0] d;
        idx = p * 64 + l * 8 + h;
        a = 7'(7'h21 + idx);
        d = 8'(idx * 29 + 3);
        clk_pre = PRE_W'(p); div_lo = DIV_W'(l); div_hi = DIV_W'(h);
        dev_addr = a; sl_addr = a; sl_ack_limit = 8;
        run_xfer(1, d, 8'h00, wr);
        lo_exp = (l << p) + 4;
        hi_exp = (h << p) + 4;
        chk("R2 one start", starts, 1);
        chk("R3 address byte with write bit", int'(rx[0]), int'({a, 1'b0}));
        chk("R3 data byte MSB first", int'(rx[1]), int'(d));
        chk("R6 bytes on bus", rx_n, 2);
        chk("R6 one stop", stops, 1);
        chk("R6 txcomp", int'(txcomp), 1);
        chk("R4 txrdy after ack", int'(txrdy), 1);
        chk("R4 no nack", int'(nack), 0);
        chk("R10 scl low min", lo_min, lo_exp);
        chk("R10 scl low max", lo_max, lo_exp);
        chk("R10 scl high min", hi_min, hi_exp);
        chk("R10 scl high max", hi_max, hi_exp);
        chk("R6 bus released", int'(scl_oe | sda_oe), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int wr;
        rst_n = 1'b0; enable = 1'b0; dev_addr = 7'h00; clk_pre = '0;
        div_lo = '0; div_hi = '0; tx_wr = 1'b0; tx_data = 8'h00;
        stat_rd = 1'b0; irq_mask = 3'b111;
        slave_clear();
        repeat (3) @(negedge clk);
        chk("R1 scl_oe in reset", int'(scl_oe), 0);
        chk("R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 txrdy", int'(txrdy), 0);
        chk("R1 txcomp", int'(txcomp), 0);
        chk("R1 nack", int'(nack), 0);
        chk("R1 irq", int'(irq), 0);

        // R11: write while disabled
        dev_addr = 7'h35; sl_addr = 7'h35; slave_clear();
        write_byte(8'hA5);
        repeat (60) @(negedge clk);
        chk("R11 no scl activity", int'(scl_oe), 0);
        chk("R11 no sda activity", int'(sda_oe), 0);
        chk("R11 no start", starts, 0);
        chk("R11 txrdy unchanged", int'(txrdy), 0);
        chk("R11 txcomp unchanged", int'(txcomp), 0);
        enable = 1'b1;

        // R10/R3/R6: full divider sweep
        for (int p = 0; p < 2; p++)
            for (int l = 0; l < 8; l++)
                for (int h = 0; h < 8; h++)
                    sweep_one(p, l, h);

        // R5: streamed transfer, also R2 txcomp clear at start
        clk_pre = 1'b0; div_lo = 3'd1; div_hi = 3'd2;
        dev_addr = 7'h4C; sl_addr = 7'h4C; sl_ack_limit = 8;
        slave_clear();
        write_byte(8'h96);
        chk("R2 txcomp cleared at start", int'(txcomp), 0);
        for (int k = 1; k < 4; k++) begin
            while (!txrdy) @(negedge clk);
            write_byte(8'(8'h96 + k * 8'h3B));
        end
        while (!txcomp) @(negedge clk);
        @(negedge clk);
        chk("R5 bytes streamed", rx_n, 5);
        chk("R5 one start", starts, 1);
        chk("R5 one stop", stops, 1);
        for (int k = 0; k < 4; k++)
            chk("R5 streamed byte", int'(rx[k + 1]), int'(8'(8'h96 + k * 8'h3B)));

        // R7/R8/R9: refused address
        dev_addr = 7'h13; sl_addr = 7'h12; irq_mask = 3'b100;
        run_xfer(2, 8'h5A, 8'h11, wr);
        chk("R7 only address sent", rx_n, 1);
        chk("R7 pending byte not taken", wr, 1);
        chk("R7 nack set", int'(nack), 1);
        chk("R7 stop after nack", stops, 1);
        chk("R7 txcomp after nack", int'(txcomp), 1);
        chk("R8 irq from nack", int'(irq), 1);
        irq_mask = 3'b000;
        @(negedge clk);
        chk("R8 irq masked", int'(irq), 0);
        irq_mask = 3'b010;
        @(negedge clk);
        chk("R8 irq from txcomp", int'(irq), 1);
        irq_mask = 3'b001;
        @(negedge clk);
        chk("R8 irq from txrdy", int'(irq), int'(txrdy));
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R9 nack cleared", int'(nack), 0);

        // R7: refused data byte with a byte already pending
        dev_addr = 7'h2E; sl_addr = 7'h2E; sl_ack_limit = 1; irq_mask = 3'b000;
        run_xfer(3, 8'hC3, 8'h24, wr);
        chk("R7 three bytes written", wr, 3);
        chk("R7 pending byte dropped", rx_n, 3);
        chk("R7 refused byte seen", int'(rx[2]), int'(8'hE7));
        chk("R7 nack on data", int'(nack), 1);
        chk("R7 txrdy stays low", int'(txrdy), 0);
        chk("R7 one stop", stops, 1);

        // R7: dropped byte does not leak into the next transfer
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        sl_ack_limit = 8;
        run_xfer(1, 8'h0F, 8'h00, wr);
        chk("R7 next transfer clean", rx_n, 2);
        chk("R7 next transfer data", int'(rx[1]), int'(8'h0F));
        chk("R9 nack stays clear", int'(nack), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule